// File: doc/BRIEF.md
# General-Purpose I/O Port with Per-Pin Configuration

This block is a parameterized general-purpose I/O port, 32 pins by default, controlled through a simple synchronous register bus. Software controls an output latch and a port-wide direction mask. Each can be written whole, or changed with write-one-to-set and write-one-to-clear aliases. Every pin also has its own configuration word that holds three fields: direction, input disconnect and pull selection. The direction bit is a single storage element. It can be reached either through the port-wide mask or through the pin's configuration word, so the two views never disagree.

An external agent can drive each pin to 0 or 1 with `ext_val`, or leave it undriven by lowering `ext_en`. Every cycle the block works out the level on each pin from three sources: the pin's own output driver, the external driver and the pull selection. When nothing drives a pin and no pull is selected, the previous level is held. The input register shows this level only for pins whose input buffer is connected. A pin that drives as an output while the external agent also drives it sets a sticky fault bit. Software clears that bit by writing 1 to it.

Top module: `gpio_port`

## Requirements
- R1: After reset, the registers at word addresses 0x00 (output latch), 0x03 (input), 0x04 (direction) and 0x07 (fault) read 0. Every configuration word at 0x40+pin reads 0x00000002.
- R2: A write to 0x05 sets the direction bits where the written data has a 1. A write to 0x06 clears those bits. A write to 0x04 loads the whole mask. Bit 0 of each pin's configuration word always equals that pin's direction bit, and writing bit 0 of a configuration word changes the direction mask.
- R3: The configuration word fields are: bit 0 direction (1 = output), bit 1 input disconnect (1 = disconnected), bits 3:2 pull (00 none, 01 pull-down, 11 pull-up; 10 acts as none). Bits 31:4 are ignored on write and read 0.
- R4: For an input pin with its buffer connected, the input register follows `ext_val` while `ext_en` is 1. When the external drive is released and no pull is selected, the last level is held.
- R5: For an undriven input pin with its buffer connected, pull-up makes the input read 1 and pull-down makes it read 0.
- R6: A write to 0x01 sets output latch bits where the data has a 1. A write to 0x02 clears them. A write to 0x00 loads the latch. One cycle after the latch or direction changes, `pin_oe` equals the direction bit and `pin_out` equals latch AND direction.
- R7: An output pin with its input connected reads its own driven value in the input register (self-stimulation). This holds even while the external agent also drives the pin.
- R8: When a pin is an output and `ext_en` is 1 on that pin, its bit in the fault register (0x07) is set on the next cycle. It stays set until 1 is written to that bit, and a new conflict wins over a clear in the same cycle.
- R9: A pin whose input is disconnected reads 0 in the input register, whatever drives the pin.
- R10: `reg_rvalid` rises one cycle after `reg_re` and `reg_rdata` is valid at that point. Unmapped addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (7) | Word address |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Read data, registered |
| reg_rvalid | output | 1 | Read data valid |
| ext_en | input | NPINS (32) | External drive enable per pin |
| ext_val | input | NPINS (32) | External drive level per pin |
| pin_out | output | NPINS (32) | Pin output level, registered |
| pin_oe | output | NPINS (32) | Pin output enable, registered |

## Verification
The bench builds the port with its default parameters: 32 pins, a 32-bit data bus and a 7-bit word address. With these values the highest pin and bit 31 of every mask can be reached, and the configuration window at 0x40 fills 32 words. The bench uses pin 0 and pin 31 to show that the direction mirror works at both ends of the mask. It uses pin 0 to step through the resolution order: own drive, then external drive, then pull, then hold. Pins that are left disconnected after reset show that the input register masks them out.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned OFS_OUT    = 0;
  localparam int unsigned OFS_OUTSET = 1;
  localparam int unsigned OFS_OUTCLR = 2;
  localparam int unsigned OFS_IN     = 3;
  localparam int unsigned OFS_DIR    = 4;
  localparam int unsigned OFS_DIRSET = 5;
  localparam int unsigned OFS_DIRCLR = 6;
  localparam int unsigned OFS_FAULT  = 7;
  localparam int unsigned OFS_CFG    = 64;

  typedef enum logic [1:0] {
    PULL_NONE = 2'b00,
    PULL_DOWN = 2'b01,
    PULL_RSVD = 2'b10,
    PULL_UP   = 2'b11
  } pull_e;
endpackage

// File: rtl/gpio_pin_resolve.sv
module gpio_pin_resolve
  import gpio_port_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  drive_dir,
  input  logic  drive_val,
  input  logic  ext_en,
  input  logic  ext_val,
  input  pull_e pull,
  output logic  level,
  output logic  pin_out,
  output logic  pin_oe,
  output logic  conflict
);
  logic level_nxt;

  // priority: own driver, external driver, pull, hold
  always_comb begin
    level_nxt = level;
    if (drive_dir)            level_nxt = drive_val;
    else if (ext_en)          level_nxt = ext_val;
    else if (pull == PULL_UP)   level_nxt = 1'b1;
    else if (pull == PULL_DOWN) level_nxt = 1'b0;
  end

  assign conflict = drive_dir & ext_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      level   <= 1'b0;
      pin_out <= 1'b0;
      pin_oe  <= 1'b0;
    end else begin
      level   <= level_nxt;
      pin_out <= drive_dir & drive_val;
      pin_oe  <= drive_dir;
    end
  end

  assert_ext_follow_R4: assert property (@(posedge clk) disable iff (rst)
    (!drive_dir && ext_en) |=> (level == $past(ext_val)));
  assert_pull_up_R5: assert property (@(posedge clk) disable iff (rst)
    (!drive_dir && !ext_en && pull == PULL_UP) |=> level);
  assert_pull_down_R5: assert property (@(posedge clk) disable iff (rst)
    (!drive_dir && !ext_en && pull == PULL_DOWN) |=> !level);
  assert_self_drive_R7: assert property (@(posedge clk) disable iff (rst)
    drive_dir |=> (level == $past(drive_val)));
  assert_out_gated_R6: assert property (@(posedge clk) disable iff (rst)
    !drive_dir |=> (!pin_out && !pin_oe));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 7
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic                   re,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  output logic                   rvalid,
  input  logic [NPINS-1:0]       level_i,
  input  logic [NPINS-1:0]       conflict_i,
  output logic [NPINS-1:0]       out_o,
  output logic [NPINS-1:0]       dir_o,
  output logic [NPINS-1:0][1:0]  pull_o
);
  logic [NPINS-1:0]      out_q, dir_q, disc_q, fault_q, fault_clr;
  logic [NPINS-1:0][1:0] pull_q;
  logic [NPINS-1:0]      wbits;
  logic [DW-1:0]         rd_word;

  assign wbits     = wdata[NPINS-1:0];
  assign fault_clr = (we && addr == ADDR_W'(OFS_FAULT)) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      dir_q   <= '0;
      disc_q  <= '1;
      pull_q  <= '0;
      fault_q <= '0;
    end else begin
      fault_q <= (fault_q & ~fault_clr) | conflict_i;
      if (we) begin
        case (addr)
          ADDR_W'(OFS_OUT):    out_q <= wbits;
          ADDR_W'(OFS_OUTSET): out_q <= out_q | wbits;
          ADDR_W'(OFS_OUTCLR): out_q <= out_q & ~wbits;
          ADDR_W'(OFS_DIR):    dir_q <= wbits;
          ADDR_W'(OFS_DIRSET): dir_q <= dir_q | wbits;
          ADDR_W'(OFS_DIRCLR): dir_q <= dir_q & ~wbits;
          default: ;
        endcase
        for (int i = 0; i < NPINS; i++) begin
          if (addr == ADDR_W'(OFS_CFG + i)) begin
            dir_q[i]  <= wdata[0];
            disc_q[i] <= wdata[1];
            pull_q[i] <= wdata[3:2];
          end
        end
      end
    end
  end

  always_comb begin
    rd_word = '0;
    case (addr)
      ADDR_W'(OFS_OUT), ADDR_W'(OFS_OUTSET), ADDR_W'(OFS_OUTCLR):
        rd_word[NPINS-1:0] = out_q;
      ADDR_W'(OFS_IN):
        rd_word[NPINS-1:0] = level_i & ~disc_q;
      ADDR_W'(OFS_DIR), ADDR_W'(OFS_DIRSET), ADDR_W'(OFS_DIRCLR):
        rd_word[NPINS-1:0] = dir_q;
      ADDR_W'(OFS_FAULT):
        rd_word[NPINS-1:0] = fault_q;
      default: ;
    endcase
    for (int i = 0; i < NPINS; i++) begin
      if (addr == ADDR_W'(OFS_CFG + i)) begin
        rd_word[0]   = dir_q[i];
        rd_word[1]   = disc_q[i];
        rd_word[3:2] = pull_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= re;
      if (re) rdata <= rd_word;
    end
  end

  assign out_o  = out_q;
  assign dir_o  = dir_q;
  assign pull_o = pull_q;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (out_q == '0 && dir_q == '0 && fault_q == '0 && disc_q == '1));
  assert_dirset_R2: assert property (@(posedge clk) disable iff (rst)
    (we && addr == ADDR_W'(OFS_DIRSET)) |=> ((dir_q & $past(wbits)) == $past(wbits)));
  assert_dirclr_R2: assert property (@(posedge clk) disable iff (rst)
    (we && addr == ADDR_W'(OFS_DIRCLR)) |=> ((dir_q & $past(wbits)) == '0));
  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (conflict_i != '0) |=> ((fault_q & $past(conflict_i)) == $past(conflict_i)));
  assert_read_latency_R10: assert property (@(posedge clk) disable iff (rst)
    re |=> rvalid);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              reg_rvalid,
  input  logic [NPINS-1:0]  ext_en,
  input  logic [NPINS-1:0]  ext_val,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);
  logic [NPINS-1:0]      level, conflict, out_l, dir_l;
  logic [NPINS-1:0][1:0] pull_l;

  gpio_regs #(.NPINS(NPINS), .DW(DW), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .we         (reg_we),
    .re         (reg_re),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .rvalid     (reg_rvalid),
    .level_i    (level),
    .conflict_i (conflict),
    .out_o      (out_l),
    .dir_o      (dir_l),
    .pull_o     (pull_l)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    gpio_pin_resolve u_pin (
      .clk       (clk),
      .rst       (rst),
      .drive_dir (dir_l[g]),
      .drive_val (out_l[g]),
      .ext_en    (ext_en[g]),
      .ext_val   (ext_val[g]),
      .pull      (pull_e'(pull_l[g])),
      .level     (level[g]),
      .pin_out   (pin_out[g]),
      .pin_oe    (pin_oe[g]),
      .conflict  (conflict[g])
    );
  end
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  localparam int NPINS = 32, DW = 32, AW = 7;
  logic clk = 0, rst = 1;
  logic we = 0, re = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic rvalid;
  logic [NPINS-1:0] ext_en = '0, ext_val = '0, pin_out, pin_oe;
  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #5 clk = ~clk;

  gpio_port #(.NPINS(NPINS), .DW(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .reg_we(we), .reg_re(re), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .reg_rvalid(rvalid),
    .ext_en(ext_en), .ext_val(ext_val), .pin_out(pin_out), .pin_oe(pin_oe));

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); we = 1; addr = AW'(a); wdata = d;
    @(negedge clk); we = 0;
  endtask

  // driver: push expectation, issue the read
  task automatic rd_expect(int a, logic [31:0] e, string tag);
    idle(2);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); re = 1; addr = AW'(a);
    @(negedge clk); re = 0;
  endtask

  task automatic chk(logic [31:0] act, logic [31:0] e, string tag);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, e);
    end
  endtask

  // monitor: compare read data as it appears
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      if (exp_q.size() == 0) chk(rdata, 32'hDEAD_BEEF, "R10 unexpected rvalid");
      else chk(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    idle(3); rst = 0;
    // R1 reset state
    rd_expect(0, 0, "R1 out");
    rd_expect(3, 0, "R1 in");
    rd_expect(4, 0, "R1 dir");
    rd_expect(7, 0, "R1 fault");
    for (int i = 0; i < NPINS; i++) rd_expect(64 + i, 32'h2, "R1 cfg");
    // R2 direction aliases and mirror
    wr(5, 32'h8000_0001);
    rd_expect(4, 32'h8000_0001, "R2 dirset");
    rd_expect(64, 32'h3, "R2 cfg0 mirror set");
    rd_expect(95, 32'h3, "R2 cfg31 mirror set");
    wr(6, 32'h8000_0001);
    rd_expect(4, 0, "R2 dirclr");
    rd_expect(95, 32'h2, "R2 cfg31 mirror clr");
    wr(4, 32'h8000_0001);
    rd_expect(64, 32'h3, "R2 dir write mirror");
    wr(4, 0);
    wr(64, 32'h1);
    rd_expect(4, 32'h1, "R2 cfg write to dir");
    // R3 field layout
    wr(64, 32'hFFFF_FFFE);
    rd_expect(64, 32'hE, "R3 upper bits ignored");
    rd_expect(4, 0, "R3 dir bit cleared");
    // R4 external follow + hold
    wr(64, 32'h0);
    ext_en[0] = 1; ext_val[0] = 0;
    rd_expect(3, 0, "R4 ext 0");
    ext_val[0] = 1;
    rd_expect(3, 1, "R4 ext 1");
    // R9 disconnected reads 0
    wr(64, 32'h2);
    rd_expect(3, 0, "R9 disconnected");
    wr(64, 32'h0);
    ext_en[0] = 0;
    rd_expect(3, 1, "R4 hold after release");
    // R5 pulls
    wr(64, 32'h4);
    rd_expect(3, 0, "R5 pull-down");
    wr(64, 32'hC);
    rd_expect(3, 1, "R5 pull-up");
    wr(64, 32'h8);
    rd_expect(3, 1, "R3 pull 10 holds");
    // R6 output latch and pin
    wr(64, 32'h3);
    wr(1, 32'h3);
    idle(1);
    chk({30'd0, pin_out[1:0]}, 32'h1, "R6 pin_out set");
    chk({30'd0, pin_oe[1:0]}, 32'h1, "R6 pin_oe");
    rd_expect(0, 32'h3, "R6 outset latch");
    wr(2, 32'h1);
    idle(1);
    chk({31'd0, pin_out[0]}, 0, "R6 pin_out clr");
    rd_expect(0, 32'h2, "R6 outclr latch");
    wr(0, 32'h0);
    // R7 self-stimulation
    wr(64, 32'h1);
    wr(1, 32'h1);
    rd_expect(3, 1, "R7 self high");
    wr(2, 32'h1);
    rd_expect(3, 0, "R7 self low");
    // R8 short flag
    wr(1, 32'h1);
    ext_en[0] = 1; ext_val[0] = 0;
    rd_expect(7, 1, "R8 fault set");
    rd_expect(3, 1, "R7 own drive wins");
    ext_en[0] = 0;
    rd_expect(7, 1, "R8 fault sticky");
    wr(7, 32'h1);
    rd_expect(7, 0, "R8 fault cleared");
    // R10 unmapped
    wr(16, 32'hFFFF_FFFF);
    rd_expect(16, 0, "R10 unmapped read");
    rd_expect(0, 32'h1, "R10 unmapped write ignored");
    idle(4);
    chk(exp_q.size(), 0, "R10 all reads returned");
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule